// File: doc/BRIEF.md
# Autoincrement Rollback Recorder

This block keeps a record of the register side effects an instruction makes while its operands are prepared, so that an instruction that hits a memory fault can be undone and started again from the beginning. Operand logic reports each autoincrement or autodecrement as an event that carries a register number and a signed change. The block keeps a log of two entries. Each entry holds the register and the net change applied to it.

An instruction-start strobe empties the log. A memory fault freezes the log, and while it is frozen the log ignores update events and start strobes. Trap software reads the frozen log through a packed status word. From it the software can subtract the recorded changes and restart the instruction. The read strobe releases the freeze. Nothing in the log changes until the next instruction start.

Top module: `undo_log`

## Requirements
- R1: After reset, status_o is all zero and frozen_o is low.
- R2: When the log is not frozen, the first update event of an instruction fills entry 0 with its register, its delta and a set valid bit. The next event for a different register fills entry 1. Entry 1 is never valid while entry 0 is invalid.
- R3: An event for a register that already has a valid entry adds its delta to that entry, modulo 32 in two's complement. It does not take a second entry.
- R4: An event for a new register when both entries are already valid leaves both entries unchanged and sets the overflow bit. The overflow bit stays set until the next instruction start that is taken while the log is not frozen.
- R5: An insn_start_i taken while the log is not frozen clears both entries and the overflow bit. An update event in the same cycle is recorded into the cleared log as entry 0.
- R6: fault_i while the log is not frozen drives frozen_o high from the next cycle. An update event in the fault cycle is still recorded.
- R7: While frozen_o is high, update events, insn_start_i and further faults leave status_o unchanged.
- R8: rd_i while frozen_o is high drives frozen_o low from the next cycle and keeps the logged contents. rd_i while the log is not frozen has no effect.
- R9: status_o is 19 bits. Bits [2:0] hold reg0, [7:3] delta0, [8] valid0, [11:9] reg1, [16:12] delta1, [17] valid1 and [18] the overflow bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| insn_start_i | input | 1 | Instruction-start strobe |
| upd_valid_i | input | 1 | An autoincrement or autodecrement event is present |
| upd_reg_i | input | 3 | Register number of the event |
| upd_delta_i | input | 5 | Signed change applied to the register |
| fault_i | input | 1 | Memory fault taken |
| rd_i | input | 1 | Status-read strobe from the trap handler |
| status_o | output | 19 | Packed log contents and overflow bit |
| frozen_o | output | 1 | Log is frozen |

## Verification
The bench repeats a register within one instruction to confirm that a design which allocates a second slot fails R3. It also pushes a sum past +15 to check that the delta wraps. A third distinct register catches a design that overwrites entry 1 or forgets the sticky overflow. Faults arrive together with an event, and starts and events arrive while the log is frozen. This exposes a design that drops the event in the fault cycle or keeps logging during the freeze. Reads are issued both while the log is frozen and while it is not, so the bench can tell whether a design releases the freeze and keeps the contents. A design that wipes the log on a read is caught, as is one that lets a stray read disturb it.

// File: rtl/undo_log_pkg.sv
package undo_log_pkg;
  parameter int unsigned REG_W   = 3;
  parameter int unsigned DELTA_W = 5;
  parameter int unsigned SLOTS   = 2;

  localparam int unsigned ENTRY_W  = 1 + DELTA_W + REG_W;
  localparam int unsigned STATUS_W = 1 + SLOTS * ENTRY_W;

  typedef struct packed {
    logic               valid;
    logic [DELTA_W-1:0] delta;
    logic [REG_W-1:0]   regno;
  } entry_t;
endpackage

// File: rtl/undo_log_slot.sv
module undo_log_slot
  import undo_log_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               new_i,
  input  logic               acc_i,
  input  logic [REG_W-1:0]   reg_i,
  input  logic [DELTA_W-1:0] delta_i,
  output entry_t             entry_o
);
  entry_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (new_i) begin
      q.valid <= 1'b1;
      q.regno <= reg_i;
      q.delta <= delta_i;
    end else if (acc_i) begin
      q.delta <= q.delta + delta_i;   // wraps modulo 2**DELTA_W
    end else if (clr_i) begin
      q <= '0;
    end
  end

  assign entry_o = q;

  // accumulation only touches the delta field
  assert_acc_keeps_reg_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !new_i && q.valid) |=> (q.valid && $stable(q.regno)));
endmodule

// File: rtl/undo_log_ctrl.sv
module undo_log_ctrl
  import undo_log_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             insn_start_i,
  input  logic             upd_valid_i,
  input  logic [REG_W-1:0] upd_reg_i,
  input  logic             fault_i,
  input  logic             rd_i,
  input  entry_t           entries_i [SLOTS],
  output logic             clr_o,
  output logic [SLOTS-1:0] new_o,
  output logic [SLOTS-1:0] acc_o,
  output logic             ovf_o,
  output logic             frozen_o
);
  logic             frozen_q, ovf_q;
  logic             en;
  logic [SLOTS-1:0] eff_v, hit, alloc;
  logic             any_hit, any_free;

  assign clr_o = insn_start_i & ~frozen_q;
  assign en    = upd_valid_i & ~frozen_q;

  always_comb begin
    logic found;
    found = 1'b0;
    alloc = '0;
    for (int i = 0; i < SLOTS; i++) begin
      eff_v[i] = entries_i[i].valid & ~clr_o;
      hit[i]   = eff_v[i] && (entries_i[i].regno == upd_reg_i);
      if (!eff_v[i] && !found) begin
        alloc[i] = 1'b1;
        found    = 1'b1;
      end
    end
    any_hit  = |hit;
    any_free = found;
  end

  assign acc_o = en ? hit : '0;
  assign new_o = (en && !any_hit) ? alloc : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frozen_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      frozen_q <= frozen_q ? ~rd_i : fault_i;
      if (en && !any_hit && !any_free) ovf_q <= 1'b1;
      else if (clr_o)                  ovf_q <= 1'b0;
    end
  end

  assign ovf_o    = ovf_q;
  assign frozen_o = frozen_q;

  assert_fault_freezes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frozen_q && fault_i) |=> frozen_q);
  assert_read_releases_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_q && rd_i) |=> !frozen_q);
  assert_ovf_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(insn_start_i && !frozen_q)) |=> ovf_q);
  assert_single_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(new_o | acc_o));
endmodule

// File: rtl/undo_log.sv
module undo_log
  import undo_log_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                insn_start_i,
  input  logic                upd_valid_i,
  input  logic [REG_W-1:0]    upd_reg_i,
  input  logic [DELTA_W-1:0]  upd_delta_i,
  input  logic                fault_i,
  input  logic                rd_i,
  output logic [STATUS_W-1:0] status_o,
  output logic                frozen_o
);
  entry_t           entries [SLOTS];
  logic             clr;
  logic [SLOTS-1:0] new_w, acc_w;
  logic             ovf;

  undo_log_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .insn_start_i (insn_start_i),
    .upd_valid_i  (upd_valid_i),
    .upd_reg_i    (upd_reg_i),
    .fault_i      (fault_i),
    .rd_i         (rd_i),
    .entries_i    (entries),
    .clr_o        (clr),
    .new_o        (new_w),
    .acc_o        (acc_w),
    .ovf_o        (ovf),
    .frozen_o     (frozen_o)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    undo_log_slot u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr),
      .new_i   (new_w[g]),
      .acc_i   (acc_w[g]),
      .reg_i   (upd_reg_i),
      .delta_i (upd_delta_i),
      .entry_o (entries[g])
    );
    assign status_o[g*ENTRY_W +: ENTRY_W] = entries[g];
  end
  assign status_o[STATUS_W-1] = ovf;

  assert_frozen_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_o |=> $stable(status_o));
  assert_start_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frozen_o && insn_start_i && !upd_valid_i) |=> (status_o == '0));
  assert_fill_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entries[1].valid |-> entries[0].valid);
endmodule

// File: tb/undo_log_tb_top.sv
module undo_log_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, uv = 1'b0, flt = 1'b0, rd = 1'b0;
  logic [2:0]  ur = '0;
  logic [4:0]  ud = '0;
  logic [18:0] status;
  logic        frozen;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  undo_log dut_i (
    .clk_i(clk), .rst_ni(rst_n), .insn_start_i(start), .upd_valid_i(uv),
    .upd_reg_i(ur), .upd_delta_i(ud), .fault_i(flt), .rd_i(rd),
    .status_o(status), .frozen_o(frozen)
  );

  // reference model state
  logic       mv [2];
  logic [2:0] mr [2];
  logic [4:0] md [2];
  logic       movf, mfrz;

  typedef struct { logic [19:0] exp; string tag; } item_t;
  item_t q [$];

  function automatic logic [19:0] pack_model();
    return {mfrz, movf, mv[1], md[1], mr[1], mv[0], md[0], mr[0]};
  endfunction

  task automatic step(input logic s, input logic v, input logic [2:0] r,
                      input logic [4:0] d, input logic f, input logic rdd,
                      input string tag);
    item_t it;
    @(negedge clk);
    start = s; uv = v; ur = r; ud = d; flt = f; rd = rdd;
    if (!mfrz) begin
      if (s) begin
        mv[0] = 0; mv[1] = 0; mr[0] = 0; mr[1] = 0; md[0] = 0; md[1] = 0; movf = 0;
      end
      if (v) begin
        if (mv[0] && mr[0] == r)      md[0] = md[0] + d;
        else if (mv[1] && mr[1] == r) md[1] = md[1] + d;
        else if (!mv[0]) begin mv[0] = 1; mr[0] = r; md[0] = d; end
        else if (!mv[1]) begin mv[1] = 1; mr[1] = r; md[1] = d; end
        else movf = 1;
      end
      mfrz = f;
    end else if (rdd) begin
      mfrz = 0;
    end
    it.exp = pack_model();
    it.tag = tag;
    @(posedge clk);
    #1 q.push_back(it);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if ({frozen, status} !== it.exp) begin
        errors++;
        $display("FAIL %s: got frozen=%b status=%h expected frozen=%b status=%h",
                 it.tag, frozen, status, it.exp[19], it.exp[18:0]);
      end
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mv[0] = 0; mv[1] = 0; mr[0] = 0; mr[1] = 0; md[0] = 0; md[1] = 0;
    movf = 0; mfrz = 0;
    #23;
    checks++;
    if (status !== '0 || frozen !== 1'b0) begin
      errors++;
      $display("FAIL R1: got frozen=%b status=%h expected frozen=0 status=00000", frozen, status);
    end
    rst_n = 1'b1;

    step(1, 0, 0, 0, 0, 0, "R5 start on empty");
    step(0, 1, 3'd5, 5'd2, 0, 0, "R2 first event to entry0 R9");
    step(0, 1, 3'd2, 5'h1f, 0, 0, "R2 second reg to entry1 R9");
    step(0, 1, 3'd5, 5'd2, 0, 0, "R3 accumulate entry0");
    step(0, 1, 3'd7, 5'd1, 0, 0, "R4 third reg overflow");
    step(0, 1, 3'd2, 5'h1f, 0, 0, "R3 accumulate entry1 with ovf set");
    step(0, 0, 0, 0, 0, 1, "R8 read while not frozen no effect");
    step(1, 1, 3'd1, 5'd4, 0, 0, "R5 start plus event clears ovf");
    step(0, 1, 3'd1, 5'd12, 0, 0, "R3 accumulate wraps past +15");
    step(0, 1, 3'd6, 5'h1e, 1, 0, "R6 event in fault cycle recorded");
    step(0, 1, 3'd3, 5'd1, 0, 0, "R7 event ignored while frozen");
    step(1, 0, 0, 0, 0, 0, "R7 start ignored while frozen");
    step(0, 0, 0, 0, 1, 0, "R7 fault while frozen");
    step(0, 0, 0, 0, 0, 1, "R8 read releases keeps log");
    step(0, 0, 0, 0, 0, 0, "R8 idle after release");
    step(0, 1, 3'd4, 5'd1, 0, 0, "R4 overflow after release");
    step(1, 0, 0, 0, 0, 0, "R5 start clears all");
    step(0, 1, 3'd0, 5'h10, 1, 0, "R6 fault with first event");
    step(0, 0, 0, 0, 1, 1, "R8 read and fault same cycle release");
    step(0, 1, 3'd0, 5'h10, 0, 0, "R3 accumulate -16 + -16 wraps");
    step(1, 0, 0, 0, 0, 0, "R5 final clear");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule